// File: doc/BRIEF.md
# Link Speed Negotiation Sequencer

This block decides, for every auto-negotiation attempt of an Ethernet PHY, which group of speed and duplex abilities is advertised to the link partner. Attempts are issued in a fixed order. The normal order offers the fastest speed first and drops the top speed after each failure. A low-power order offers only 10 Mb/s first and adds faster speeds one step at a time. A simple handshake stands in for the line-side negotiation. The block pulses a restart strobe together with a new advertisement. The surrounding logic returns one result pulse marked success or failure. On success the block raises a link flag and reports the speed it resolved.

The block also owns a hardware-only sleep state for an unplugged cable. This state is used only while auto-negotiation is enabled. In sleep, the block's clock-gate enable drops, so that everything except the reference and MAC-side clocks can be gated. When energy is seen on the cable again, a fresh negotiation starts within a bounded number of cycles. With a forced speed, the block advertises only that speed and never sleeps.

Top module: `link_speed_sequencer`

## Requirements
- R1: After reset, and again after each cable reconnect or renegotiate request, the first restart strobe comes START_DLY to START_DLY+1 cycles after the trigger. In reset `link_up` and `restart` are 0 and `clk_gate_en` is 1.
- R2: Mask bits are pairs: [5:4] 1000 Mb/s full/half, [3:2] 100 full/half, [1:0] 10 full/half. In the normal order the attempts advertise 6'h3F, 6'h0F, 6'h03. After a failure result the next strobe comes exactly FAIL_TMO cycles after the cycle that sampled the failure.
- R3: After the third attempt of a sequence fails, the sequence wraps to its first advertisement and keeps going.
- R4: In the low-power order the attempts advertise 6'h03, 6'h0F, 6'h3F. A partner that accepts only 1000 and 100 ends up linked at 100.
- R5: The order is chosen when a negotiation starts. In the non-active power state (`nonactive`=1), the low-power order is used exactly when `lplu_cfg_nonactive`=1. In the active state, `policy_en`=1 picks the order from `policy_low`; otherwise `lplu_bit` picks it (1 = low-power order).
- R6: A change of `lplu_bit` while linked causes no restart strobe and does not drop the link. The new value applies at the next negotiation started for another reason.
- R7: With `an_enable`=1 and `cable_present`=0, the block sleeps: `clk_gate_en`=0 and `link_up`=0 one cycle later, and no strobes are issued. On reconnect, negotiation restarts from the first step of the order.
- R8: With `an_enable`=0, each attempt advertises only the pair of `force_speed`. Removing the cable drops `link_up` but keeps `clk_gate_en`=1.
- R9: `speed` is 2'b00 for 10, 2'b01 for 100 and 2'b10 for 1000. It equals the highest speed in the mask of the attempt that succeeded, and it is meaningful only while `link_up`=1.
- R10: `restart` is a one-cycle pulse. It appears in the same cycle as the new `adv_mask` and never while `link_up`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| an_enable | input | 1 | 1 = auto-negotiation, 0 = forced speed |
| force_speed | input | 2 | Forced speed code (00=10, 01=100, 10=1000) |
| lplu_bit | input | 1 | Low-power-first setting for the active state |
| nonactive | input | 1 | 1 = system in a non-active power state |
| lplu_cfg_nonactive | input | 1 | Configuration bit enabling low-power-first in non-active states |
| policy_en | input | 1 | Active-state speed policy override valid |
| policy_low | input | 1 | Override value: 1 = lowest speed first |
| cable_present | input | 1 | Energy detected on the cable |
| renegotiate | input | 1 | Request to start a new negotiation |
| res_valid | input | 1 | One-cycle attempt result pulse |
| res_ok | input | 1 | Attempt result: 1 = link formed |
| adv_mask | output | 6 | Current advertisement mask |
| restart | output | 1 | Negotiation restart strobe |
| link_up | output | 1 | Link established |
| speed | output | 2 | Resolved speed code |
| clk_gate_en | output | 1 | 0 = internal clocks may be gated |

## Verification
The properties assume that `res_valid` comes only as a single pulse after a strobe, and that the mode inputs change only while no negotiation is being decided. The bench's partner model replies three cycles after each strobe. It changes mode pins only while the link is up or the block is idle. `cable_present` and `renegotiate` are driven on the falling edge, so each is seen whole at the next sampling edge. Partner abilities are chosen so that each order and the wrap can be observed attempt by attempt.

// File: rtl/lsn_pkg.sv
// Shared constants and types for the link speed negotiation sequencer.
// Assumes three speeds, each advertised as a full/half duplex pair.
package lsn_pkg;
    localparam int NUM_SPD = 3;
    localparam int MASK_W  = 2 * NUM_SPD;
    localparam int SPD_W   = 2;

    typedef logic [SPD_W-1:0] spd_t;

    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_DELAY,
        ST_TRY,
        ST_BACKOFF,
        ST_LINKED
    } seq_state_t;
endpackage

// File: rtl/lsn_timer.sv
// Saturating cycle counter with synchronous clear; done stays high once
// LIMIT-1 is reached. Assumes LIMIT >= 1.
module lsn_timer #(
    parameter int unsigned LIMIT = 16,
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(LIMIT - 1));

    // count up while enabled, hold at the limit, clear on request
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (en && !done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lsn_mode_sel.sv
// Chooses between highest-first and lowest-first ordering.
// The non-active configuration bit rules in non-active states; in the
// active state a valid policy override beats the register bit.
module lsn_mode_sel (
    input  logic nonactive,
    input  logic cfg_nonactive,
    input  logic policy_en,
    input  logic policy_low,
    input  logic reg_low,
    output logic low_first
);
    // priority selection of the ordering
    always_comb begin
        if (nonactive) begin
            low_first = cfg_nonactive;
        end else if (policy_en) begin
            low_first = policy_low;
        end else begin
            low_first = reg_low;
        end
    end
endmodule

// File: rtl/lsn_adv_map.sv
// Maps (mode, step) or a forced speed onto an advertisement mask.
// With negotiation, every pair up to the top speed is offered; forced
// mode offers only the forced pair. Codes above the top speed clamp.
module lsn_adv_map
    import lsn_pkg::*;
(
    input  logic              an_en,
    input  logic              low_first,
    input  logic [1:0]        step,
    input  spd_t              force_spd,
    output logic [MASK_W-1:0] mask
);
    localparam logic [1:0] LAST = 2'(NUM_SPD - 1);

    logic [1:0] top;

    // top speed code of this attempt
    always_comb begin
        if (an_en) begin
            top = low_first ? step : (LAST - step);
        end else begin
            top = (force_spd > LAST) ? LAST : force_spd;
        end
    end

    for (genvar g = 0; g < NUM_SPD; g++) begin : g_pair
        // offer pair g when it lies inside the allowed range
        always_comb begin
            if (an_en) begin
                mask[2*g +: 2] = (2'(g) <= top) ? 2'b11 : 2'b00;
            end else begin
                mask[2*g +: 2] = (2'(g) == top) ? 2'b11 : 2'b00;
            end
        end
    end
endmodule

// File: rtl/link_speed_sequencer.sv
// Top of the negotiation sequencer. A state machine waits for the start
// delay, issues attempts with a strobe and mask, waits out a timeout after
// each failure and advances (wrapping after the last step). It sleeps on
// cable loss when negotiation is enabled. The attempt result is assumed to
// be a single-cycle pulse that follows a strobe.
module link_speed_sequencer
    import lsn_pkg::*;
#(
    parameter int unsigned START_DLY = 40,
    parameter int unsigned FAIL_TMO  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              an_enable,
    input  logic [1:0]        force_speed,
    input  logic              lplu_bit,
    input  logic              nonactive,
    input  logic              lplu_cfg_nonactive,
    input  logic              policy_en,
    input  logic              policy_low,
    input  logic              cable_present,
    input  logic              renegotiate,
    input  logic              res_valid,
    input  logic              res_ok,
    output logic [MASK_W-1:0] adv_mask,
    output logic              restart,
    output logic              link_up,
    output logic [1:0]        speed,
    output logic              clk_gate_en
);
    localparam logic [1:0] LAST = 2'(NUM_SPD - 1);

    seq_state_t        state_q, nxt;
    logic [1:0]        step_q, sel_step;
    logic              low_q, sel_low, low_sel;
    logic [MASK_W-1:0] adv_q, map_mask;
    logic              restart_q, link_q;
    spd_t              spd_q, mask_top;
    logic              start, advance, sleep_req, drop;
    logic              dly_done, bk_done;

    lsn_mode_sel u_mode (
        .nonactive     (nonactive),
        .cfg_nonactive (lplu_cfg_nonactive),
        .policy_en     (policy_en),
        .policy_low    (policy_low),
        .reg_low       (lplu_bit),
        .low_first     (low_sel)
    );

    lsn_timer #(.LIMIT(START_DLY)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((state_q != ST_DELAY) || !cable_present),
        .en    (1'b1),
        .done  (dly_done)
    );

    lsn_timer #(.LIMIT(FAIL_TMO)) u_bk (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_BACKOFF),
        .en    (1'b1),
        .done  (bk_done)
    );

    // step and ordering for the next attempt: first step on a fresh start
    always_comb begin
        sel_step = start ? 2'd0 : ((step_q == LAST) ? 2'd0 : step_q + 2'd1);
        sel_low  = start ? low_sel : low_q;
    end

    lsn_adv_map u_map (
        .an_en     (an_enable),
        .low_first (sel_low),
        .step      (sel_step),
        .force_spd (force_speed),
        .mask      (map_mask)
    );

    // highest speed present in the active advertisement
    always_comb begin
        mask_top = '0;
        for (int s = 0; s < NUM_SPD; s++) begin
            if (adv_q[2*s +: 2] != 2'b00) mask_top = SPD_W'(s);
        end
    end

    // next-state decision of the sequencer
    always_comb begin
        sleep_req = an_enable && !cable_present;
        drop      = renegotiate || !cable_present;
        nxt       = state_q;
        start     = 1'b0;
        advance   = 1'b0;
        unique case (state_q)
            ST_SLEEP: begin
                if (!sleep_req) nxt = ST_DELAY;
            end
            ST_DELAY: begin
                if (sleep_req) begin
                    nxt = ST_SLEEP;
                end else if (cable_present && dly_done) begin
                    nxt   = ST_TRY;
                    start = 1'b1;
                end
            end
            ST_TRY: begin
                if (sleep_req)      nxt = ST_SLEEP;
                else if (drop)      nxt = ST_DELAY;
                else if (res_valid) nxt = res_ok ? ST_LINKED : ST_BACKOFF;
            end
            ST_BACKOFF: begin
                if (sleep_req) begin
                    nxt = ST_SLEEP;
                end else if (drop) begin
                    nxt = ST_DELAY;
                end else if (bk_done) begin
                    nxt     = ST_TRY;
                    advance = 1'b1;
                end
            end
            ST_LINKED: begin
                if (sleep_req) nxt = ST_SLEEP;
                else if (drop) nxt = ST_DELAY;
            end
            default: nxt = ST_DELAY;
        endcase
    end

    // state, advertisement, strobe and link registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_DELAY;
            step_q    <= '0;
            low_q     <= 1'b0;
            adv_q     <= '0;
            restart_q <= 1'b0;
            link_q    <= 1'b0;
            spd_q     <= '0;
        end else begin
            state_q   <= nxt;
            restart_q <= start || advance;
            link_q    <= (nxt == ST_LINKED);
            if (start || advance) begin
                step_q <= sel_step;
                low_q  <= sel_low;
                adv_q  <= map_mask;
            end
            if (state_q == ST_TRY && nxt == ST_LINKED) begin
                spd_q <= mask_top;
            end
        end
    end

    assign adv_mask    = adv_q;
    assign restart     = restart_q;
    assign link_up     = link_q;
    assign speed       = spd_q;
    assign clk_gate_en = (state_q != ST_SLEEP);
endmodule

// File: rtl/lsn_checker.sv
// Port-level properties of the sequencer, attached by bind below.
module lsn_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       an_enable,
    input logic       cable_present,
    input logic       renegotiate,
    input logic [5:0] adv_mask,
    input logic       restart,
    input logic       link_up,
    input logic [1:0] speed,
    input logic       clk_gate_en
);
    a_r10_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart);

    a_r10_strobe_link_down: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !link_up);

    a_r7_sleep_link_down: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_gate_en |-> !link_up);

    a_r8_forced_no_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        !an_enable |=> clk_gate_en);

    a_r6_linked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && !renegotiate && cable_present) |=> (!restart && link_up));

    a_r9_speed_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |-> ((speed == 2'b10 && adv_mask[5:4] != 2'b00) ||
                     (speed == 2'b01 && adv_mask[5:4] == 2'b00 && adv_mask[3:2] != 2'b00) ||
                     (speed == 2'b00 && adv_mask[5:2] == 4'b0000)));
endmodule

bind link_speed_sequencer lsn_checker u_lsn_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .an_enable     (an_enable),
    .cable_present (cable_present),
    .renegotiate   (renegotiate),
    .adv_mask      (adv_mask),
    .restart       (restart),
    .link_up       (link_up),
    .speed         (speed),
    .clk_gate_en   (clk_gate_en)
);

// File: tb/tb_link_speed_sequencer.sv
// Scoreboard bench: tasks queue the expected masks, a monitor pops one per
// strobe; a partner model answers every attempt.
module tb_link_speed_sequencer;
    localparam int DLY = 40;
    localparam int TMO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic an_enable = 1'b1, lplu_bit = 1'b0, nonactive = 1'b0;
    logic lplu_cfg_nonactive = 1'b0, policy_en = 1'b0, policy_low = 1'b0;
    logic cable_present = 1'b1, renegotiate = 1'b0;
    logic res_valid = 1'b0, res_ok = 1'b0;
    logic [1:0] force_speed = 2'b00;
    logic [5:0] adv_mask;
    logic restart, link_up, clk_gate_en;
    logic [1:0] speed;

    int total = 0, fails = 0, cyc = 0, strobe_cnt = 0;
    int last_strobe_cyc = 0, fail_cyc = 0, t0 = 0, base = 0;
    bit fail_pend = 0, finished = 0;
    logic [2:0] partner = 3'b111;   // bit s = partner links at speed code s
    logic [5:0] exp_q[$];

    link_speed_sequencer #(.START_DLY(DLY), .FAIL_TMO(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .an_enable(an_enable), .force_speed(force_speed),
        .lplu_bit(lplu_bit), .nonactive(nonactive), .lplu_cfg_nonactive(lplu_cfg_nonactive),
        .policy_en(policy_en), .policy_low(policy_low), .cable_present(cable_present),
        .renegotiate(renegotiate), .res_valid(res_valid), .res_ok(res_ok),
        .adv_mask(adv_mask), .restart(restart), .link_up(link_up), .speed(speed),
        .clk_gate_en(clk_gate_en)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // watchdog and cycle counter
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
    end

    // monitor: compare each strobe's mask with the scoreboard
    always @(negedge clk) begin
        if (rst_n && restart) begin
            if (exp_q.size() == 0) begin
                chk(0, "R10 unexpected strobe", adv_mask, 0);
            end else begin
                logic [5:0] m;
                m = exp_q.pop_front();
                chk(adv_mask == m, "R2/R4/R8 mask order", adv_mask, m);
            end
            if (fail_pend) begin
                chk(cyc - fail_cyc == TMO, "R2 fail timeout", cyc - fail_cyc, TMO);
                fail_pend = 0;
            end
            strobe_cnt++;
            last_strobe_cyc = cyc;
        end
    end

    // partner model: answer three cycles after each strobe
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && restart) begin
                logic [5:0] m;
                int top;
                m = adv_mask;
                repeat (3) @(negedge clk);
                top = m[5] ? 2 : (m[3] ? 1 : 0);
                res_ok = partner[top];
                res_valid = 1'b1;
                if (!partner[top]) begin
                    fail_cyc = cyc + 1;
                    fail_pend = 1;
                end
                @(negedge clk);
                res_valid = 1'b0;
            end
        end
    end

    task automatic reneg();
        @(negedge clk); renegotiate = 1'b1;
        @(negedge clk); renegotiate = 1'b0;
    endtask

    task automatic wait_link(input string req);
        int n = 0;
        while (!(link_up && exp_q.size() == 0) && n < 3000) begin
            @(negedge clk); n++;
        end
        chk(link_up, req, link_up, 1);
    endtask

    initial begin
        // R1: reset state
        exp_q.push_back(6'h3F);
        repeat (4) @(negedge clk);
        chk(link_up == 0, "R1 reset link_up", link_up, 0);
        chk(restart == 0, "R1 reset restart", restart, 0);
        chk(clk_gate_en == 1, "R1 reset gate", clk_gate_en, 1);
        rst_n = 1'b1; t0 = cyc;
        wait_link("R1 first link");
        chk(last_strobe_cyc - t0 >= DLY && last_strobe_cyc - t0 <= DLY + 1,
            "R1 start delay", last_strobe_cyc - t0, DLY);
        chk(speed == 2'b10, "R9 speed 1000", speed, 2);

        // R2: normal fallback to 10
        partner = 3'b001;
        exp_q.push_back(6'h3F); exp_q.push_back(6'h0F); exp_q.push_back(6'h03);
        reneg();
        wait_link("R2 link at 10");
        chk(speed == 2'b00, "R2 speed 10", speed, 0);

        // R3: all three fail, wrap to first step
        partner = 3'b000;
        exp_q.push_back(6'h3F); exp_q.push_back(6'h0F);
        exp_q.push_back(6'h03); exp_q.push_back(6'h3F);
        base = strobe_cnt;
        reneg();
        while (strobe_cnt < base + 4 && cyc < 100000) @(negedge clk);
        partner = 3'b111;
        wait_link("R3 wrap link");
        chk(speed == 2'b10, "R3 speed after wrap", speed, 2);

        // R6: register bit change while linked does nothing now
        base = strobe_cnt;
        @(negedge clk); lplu_bit = 1'b1;
        repeat (60) @(negedge clk);
        chk(strobe_cnt == base, "R6 no restart", strobe_cnt - base, 0);
        chk(link_up == 1, "R6 link kept", link_up, 1);

        // R4: low-power order, partner 1000/100 links at 100
        partner = 3'b110;
        exp_q.push_back(6'h03); exp_q.push_back(6'h0F);
        reneg();
        wait_link("R4 lowfirst link");
        chk(speed == 2'b01, "R4 speed 100", speed, 1);

        // R5: override beats register bit in active state
        partner = 3'b111;
        policy_en = 1'b1; policy_low = 1'b0;
        exp_q.push_back(6'h3F);
        reneg();
        wait_link("R5 override link");
        // R5: non-active with config bit clear
        policy_en = 1'b0; nonactive = 1'b1; lplu_cfg_nonactive = 1'b0;
        exp_q.push_back(6'h3F);
        reneg();
        wait_link("R5 nonactive cfg0");
        // R5: non-active with config bit set
        lplu_cfg_nonactive = 1'b1;
        exp_q.push_back(6'h03);
        reneg();
        wait_link("R5 nonactive cfg1");
        chk(speed == 2'b00, "R5 speed 10", speed, 0);
        nonactive = 1'b0; lplu_bit = 1'b0;

        // R7: cable removal sleeps, reconnect restarts
        @(negedge clk); cable_present = 1'b0;
        @(negedge clk);
        chk(clk_gate_en == 0, "R7 gated", clk_gate_en, 0);
        chk(link_up == 0, "R7 link down", link_up, 0);
        base = strobe_cnt;
        repeat (80) @(negedge clk);
        chk(strobe_cnt == base, "R7 no strobes asleep", strobe_cnt - base, 0);
        exp_q.push_back(6'h3F);
        cable_present = 1'b1; t0 = cyc;
        wait_link("R7 relink");
        chk(last_strobe_cyc - t0 >= DLY && last_strobe_cyc - t0 <= DLY + 1,
            "R1 reconnect delay", last_strobe_cyc - t0, DLY + 1);

        // R8: forced 100
        an_enable = 1'b0; force_speed = 2'b01;
        exp_q.push_back(6'h0C);
        reneg();
        wait_link("R8 forced link");
        chk(speed == 2'b01, "R8 forced speed", speed, 1);
        @(negedge clk); cable_present = 1'b0;
        @(negedge clk);
        chk(clk_gate_en == 1, "R8 no sleep forced", clk_gate_en, 1);
        chk(link_up == 0, "R8 link down", link_up, 0);
        repeat (30) @(negedge clk);
        chk(clk_gate_en == 1, "R8 still awake", clk_gate_en, 1);
        exp_q.push_back(6'h0C);
        cable_present = 1'b1;
        wait_link("R8 forced relink");

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all strobes seen", exp_q.size(), 0);
        finished = 1;
        summary();
    end
endmodule